// File: doc/BRIEF.md
# External Interrupt Request Latch Controller

This block turns one active-low external interrupt pin into an interrupt request for a CPU. The asynchronous pin first passes through a synchronizer chain. A falling edge on the synchronized level then sets a request latch. The latch stays set until one of three things clears it: the CPU's vector-fetch acknowledge strobe, a software acknowledge written through the control register, or reset. The synchronized level is also brought out on its own port, so that pin-level branch tests can read it.

A small control register sets the behaviour. One bit selects the sense: edge only, or edge plus low level. A second bit masks the request going to the CPU without discarding the latched state. Writing 1 to a third bit gives the software acknowledge. A read-only flag shows the request before masking. In level mode a request stays active while the pin is low. It drops only after the pin has gone high and an acknowledge has occurred, and these two events may happen in either order.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0 and `reg_rdata` is all zeros (mask 0, mode 0, flag 0). `pin_level` is 1 until the pin value has passed through the synchronizer.
- R2: The request latch sets on the clock edge that follows the cycle in which `pin_level` falls. With the default two-stage synchronizer, a low driven on `irq_pin_n` sets the flag three clock edges later.
- R3: A `vec_fetch_ack` pulse clears the latch. So does a register write with bit 2 (acknowledge) set. The latch reads as clear from the next cycle on.
- R4: While mask bit 0 is 1, `irq_out` is 0 and the latched request is kept. Clearing the mask forwards a held request to `irq_out` in the cycle after the write. `irq_out` is never 1 unless flag bit 3 is 1.
- R5: With mode bit 1 at 0, one acknowledge clears the request, even while the pin is still low.
- R6: With mode bit 1 at 1, the request (flag bit 3) stays 1 for as long as `pin_level` is 0, even after an acknowledge.
- R7: With mode bit 1 at 1, the request drops only once `pin_level` is 1 and an acknowledge has occurred, in either order.
- R8: A falling edge that arrives after an acknowledge latches a new request. If the edge and an acknowledge fall in the same cycle, the edge wins and the latch stays set.
- R9: Reset clears the latch and the mode bit, so the request is removed even while the pin is held low.
- R10: `pin_level` follows `irq_pin_n` delayed by `SYNC_STAGES` clock edges.
- R11: `reg_rdata` reads mask in bit 0, mode in bit 1, 0 in bit 2 (acknowledge), the unmasked request in bit 3, and 0 in all higher bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| vec_fetch_ack | input | 1 | One-cycle strobe from the CPU on fetching this interrupt's vector |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | DATA_W | Write data: bit 0 mask, bit 1 mode, bit 2 acknowledge |
| reg_rdata | output | DATA_W | Read data: bit 0 mask, bit 1 mode, bit 2 zero, bit 3 flag |
| irq_out | output | 1 | Masked interrupt request to the CPU |
| pin_level | output | 1 | Synchronized pin level for pin-test instructions |

## Verification
The hardest situation to reach is a falling edge that arrives in the same cycle as an acknowledge. The edge only exists for one cycle, two synchronizer stages after the pin moves, so the stimulus has to time the acknowledge against the pin change. A directed sequence drives the pin low and then issues the acknowledge write exactly on the third edge. The level-mode clear is checked in both orders, acknowledge-then-release and release-then-acknowledge. A long random run then mixes pin toggles, vector fetches and register writes, and every cycle is compared against a bench model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int unsigned MASK_BIT   = 0;
   localparam int unsigned MODE_BIT   = 1;
   localparam int unsigned ACK_BIT    = 2;
   localparam int unsigned FLAG_BIT   = 3;
   localparam int unsigned CTRL_MIN_W = 4;

   typedef struct packed {
      logic level_mode;
      logic mask;
   } irq_ctrl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic level_o,
   output logic fall_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   // pin idles high: reset the chain to the inactive level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], pin_n};
         prev_q  <= stage_q[LAST];
      end
   end

   assign level_o = stage_q[LAST];
   assign fall_o  = prev_q & ~stage_q[LAST];
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic lat_o
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_o <= 1'b0;
      else if (set_i) lat_o <= 1'b1;
      else if (clr_i) lat_o <= 1'b0;
   end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
   import ext_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output irq_ctrl_t         ctrl_o,
   output logic              ack_o
);
   if (DATA_W < CTRL_MIN_W) begin : g_bad_width
      $error("irq_ctrl_reg: DATA_W must be at least CTRL_MIN_W");
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
      end else if (wr_i) begin
         ctrl_o.mask       <= wdata_i[MASK_BIT];
         ctrl_o.level_mode <= wdata_i[MODE_BIT];
      end
   end

   assign ack_o = wr_i & wdata_i[ACK_BIT];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_pin_n,
   input  logic              vec_fetch_ack,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out,
   output logic              pin_level
);
   localparam int unsigned PAD_W = DATA_W - CTRL_MIN_W;

   logic      level_s;
   logic      fall_s;
   logic      sw_ack;
   logic      lat_q;
   logic      pending;
   irq_ctrl_t ctrl;

   irq_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (irq_pin_n),
      .level_o(level_s),
      .fall_o (fall_s)
   );

   irq_ctrl_reg #(.DATA_W(DATA_W)) i_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (reg_wr),
      .wdata_i(reg_wdata),
      .ctrl_o (ctrl),
      .ack_o  (sw_ack)
   );

   irq_req_latch i_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(fall_s),
      .clr_i(vec_fetch_ack | sw_ack),
      .lat_o(lat_q)
   );

   // level mode keeps the request alive while the pin is low
   assign pending   = lat_q | (ctrl.level_mode & ~level_s);
   assign irq_out   = pending & ~ctrl.mask;
   assign pin_level = level_s;

   if (PAD_W > 0) begin : g_pad
      assign reg_rdata = {{PAD_W{1'b0}}, pending, 1'b0, ctrl.level_mode, ctrl.mask};
   end else begin : g_nopad
      assign reg_rdata = {pending, 1'b0, ctrl.level_mode, ctrl.mask};
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import ext_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vec_fetch_ack,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_out,
   input logic              pin_level
);
   logic unused_rbits;
   assign unused_rbits = ^reg_rdata;

   // R4
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[MASK_BIT] |-> !irq_out);

   // R4
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> reg_rdata[FLAG_BIT]);

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[MODE_BIT] && !pin_level) |-> reg_rdata[FLAG_BIT]);

   // R2
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_level) |=> reg_rdata[FLAG_BIT]);

   // R5
   edge_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_fetch_ack && pin_level && !reg_rdata[MODE_BIT] && !reg_wr)
      |=> !reg_rdata[FLAG_BIT]);
endmodule

bind ext_irq_ctrl irq_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vec_fetch_ack(vec_fetch_ack),
   .reg_wr       (reg_wr),
   .reg_rdata    (reg_rdata),
   .irq_out      (irq_out),
   .pin_level    (pin_level)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_pin_n = 1'b1;
   logic          vec_fetch_ack = 1'b0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_out;
   logic          pin_level;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // bench model state
   logic m_s0, m_s1, m_prev, m_lat, m_mode, m_mask;

   always #10 clk = ~clk;

   ext_irq_ctrl #(.SYNC_STAGES(2), .DATA_W(DW)) i_ext_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
      .vec_fetch_ack(vec_fetch_ack), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out), .pin_level(pin_level)
   );

   function automatic logic exp_pend();
      return m_lat | (m_mode & ~m_s1);
   endfunction

   function automatic logic [DW-1:0] exp_rdata();
      logic [DW-1:0] r = '0;
      r[0] = m_mask;
      r[1] = m_mode;
      r[3] = exp_pend();
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_s0 = 1; m_s1 = 1; m_prev = 1; m_lat = 0; m_mode = 0; m_mask = 0;
   endtask

   task automatic compare_all();
      chk("R4 irq_out vs model", irq_out, exp_pend() & ~m_mask);
      chk("R10 pin_level vs model", pin_level, m_s1);
      chk("R11 reg_rdata vs model", reg_rdata, exp_rdata());
   endtask

   // drive at negedge, model the edge, check at next negedge
   task automatic step(input logic pin, input logic vf, input logic wr, input logic [DW-1:0] wd);
      logic fall, clr;
      irq_pin_n = pin; vec_fetch_ack = vf; reg_wr = wr; reg_wdata = wd;
      @(posedge clk);
      fall = m_prev & ~m_s1;
      clr  = vf | (wr & wd[2]);
      if (fall) m_lat = 1;
      else if (clr) m_lat = 0;
      if (wr) begin m_mask = wd[0]; m_mode = wd[1]; end
      m_prev = m_s1; m_s1 = m_s0; m_s0 = pin;
      @(negedge clk);
      compare_all();
   endtask

   task automatic pin_steps(input logic pin, input int n);
      for (int i = 0; i < n; i++) step(pin, 0, 0, '0);
   endtask

   task automatic do_reset(input logic pin);
      irq_pin_n = pin; vec_fetch_ack = 0; reg_wr = 0; reg_wdata = '0;
      rst_n = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      logic pin;
      seed = 32'h1F2E3D4C;
      void'($urandom(seed));

      // R1 reset state
      do_reset(1);
      chk("R1 irq_out after reset", irq_out, 0);
      chk("R1 rdata after reset", reg_rdata, 0);
      chk("R1 pin_level after reset", pin_level, 1);

      // R2 / R10 edge latching timing
      step(0, 0, 0, '0);
      chk("R10 pin_level after one edge", pin_level, 1);
      step(0, 0, 0, '0);
      chk("R10 pin_level after two edges", pin_level, 0);
      chk("R2 flag not yet set", reg_rdata[3], 0);
      step(0, 0, 0, '0);
      chk("R2 flag set on third edge", reg_rdata[3], 1);
      chk("R2 irq_out set", irq_out, 1);

      // R5 edge mode: one ack clears while pin low
      step(0, 0, 1, 8'h04);
      chk("R5 ack clears with pin low", irq_out, 0);
      pin_steps(0, 2);
      chk("R5 stays clear while pin low", reg_rdata[3], 0);

      // R4 mask holds, unmask forwards; R3 vector fetch clears
      pin_steps(1, 3);
      step(1, 0, 1, 8'h01);
      pin_steps(0, 3);
      chk("R4 flag held under mask", reg_rdata[3], 1);
      chk("R4 irq_out masked", irq_out, 0);
      step(0, 0, 1, 8'h00);
      chk("R4 unmask forwards request", irq_out, 1);
      step(0, 1, 0, '0);
      chk("R3 vector fetch clears", irq_out, 0);

      // R6 / R7 level mode, ack before release
      pin_steps(1, 3);
      step(1, 0, 1, 8'h02);
      pin_steps(0, 3);
      chk("R6 level request set", reg_rdata[3], 1);
      step(0, 0, 1, 8'h06);
      chk("R6 request survives ack while low", reg_rdata[3], 1);
      step(1, 0, 0, '0);
      chk("R7 still set before release seen", reg_rdata[3], 1);
      step(1, 0, 0, '0);
      chk("R7 drops after ack then release", reg_rdata[3], 0);

      // R7 release before ack
      pin_steps(0, 3);
      pin_steps(1, 3);
      chk("R7 held after release without ack", irq_out, 1);
      step(1, 1, 0, '0);
      chk("R7 drops after release then fetch", irq_out, 0);

      // R8 edge and ack in the same cycle: edge wins
      step(1, 0, 1, 8'h00);
      step(0, 0, 0, '0);
      step(0, 0, 0, '0);
      step(0, 0, 1, 8'h04);
      chk("R8 edge beats simultaneous ack", reg_rdata[3], 1);
      step(0, 0, 1, 8'h04);
      chk("R3 software ack clears", reg_rdata[3], 0);
      pin_steps(1, 3);
      pin_steps(0, 3);
      chk("R8 new edge after ack relatches", reg_rdata[3], 1);
      step(0, 1, 0, '0);

      // R9 reset with pin held low in level mode
      pin_steps(1, 3);
      step(1, 0, 1, 8'h02);
      pin_steps(0, 3);
      chk("R9 request before reset", reg_rdata[3], 1);
      do_reset(0);
      chk("R9 request removed by reset", reg_rdata[3], 0);
      chk("R9 mode cleared by reset", reg_rdata[1], 0);
      chk("R9 irq_out cleared by reset", irq_out, 0);
      pin_steps(0, 3);

      // R11 readback of an all-ones write
      step(0, 0, 1, 8'hFF);
      chk("R11 ack bit reads zero", reg_rdata[2], 0);
      chk("R11 upper bits read zero", reg_rdata[7:4], 0);
      chk("R11 mask and mode read back", reg_rdata[1:0], 2'b11);

      // random phase against the model
      do_reset(1);
      pin = 1;
      for (int i = 0; i < 3000; i++) begin
         logic vf, wr;
         logic [DW-1:0] wd;
         if ($urandom_range(5) == 0) pin = ~pin;
         vf = ($urandom_range(9) == 0);
         wr = ($urandom_range(7) == 0);
         wd = DW'($urandom);
         step(pin, vf, wr, wd);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule